// File: doc/BRIEF.md
# Quad Vector Load Alignment Unit

This unit moves a partial 128-bit vector from a byte-addressed data memory into one register of a vector register file, one byte per cycle. Two load flavours exist. The forward quad load starts at the effective address and runs to the end of the 16-byte memory block that holds it. The rest load starts at the aligned start of that block and stops just short of the effective address. Used together, the two flavours let software assemble an unaligned 16-byte vector from two adjacent memory blocks.

A start pulse provides a 32-bit base value, a signed offset counted in 16-byte units, a starting byte lane and a target register index. The unit computes the byte range, reads the memory through a synchronous read port with one cycle of latency, and writes each returned byte into the register file through a byte-wide write port. The transfer is also limited by the starting lane, so it never runs past lane 15. Lanes that fall outside the range are never written.

Top module: `quad_vec_load`

## Requirements
- R1: While reset is asserted, and after it is released until a start, busy, done, mem_rd_en and vr_we are all 0.
- R2: The effective address is base + 16*ofs (ofs is two's complement), reduced modulo the 4096-byte memory size. Read addresses are taken from it.
- R3: With op=0 (quad load), memory bytes are read in ascending order from the effective address. The byte read k-th is written to lane elem+k.
- R4: With op=0, the number of bytes moved is min(16 - ea[3:0], 16 - elem). An aligned address with elem=0 therefore moves all 16 bytes.
- R5: With op=1 (rest load), reading starts at the effective address with its low four bits cleared. The number of bytes moved is min(ea[3:0], 16 - elem), written to lanes elem upward. An aligned address moves nothing, and done still pulses.
- R6: Register lanes outside the transferred range, and all other registers, keep their previous contents.
- R7: One byte is read per cycle while bytes remain. Each read is followed in the next cycle by a write, with vr_wdata equal to mem_rdata.
- R8: A start seen while busy is low raises busy in the next cycle. done is a one-cycle pulse that arrives count+1 cycles after the start edge, with busy low from then on. A start seen while busy is ignored.
- R9: Address bits above the memory size are ignored, and an effective address below zero wraps to the top of the memory.
- R10: Every write of a transfer carries, on vr_idx, the register index that was given with its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a load (accepted only when idle) |
| op | input | 1 | 0 = quad load, 1 = rest load |
| base | input | 32 | Base address value |
| ofs | input | 7 | Signed offset in 16-byte units |
| elem | input | 4 | First register lane to write |
| vreg | input | 5 | Target vector register index |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 12 | Memory byte address |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the strobe |
| vr_we | output | 1 | Register byte write enable |
| vr_idx | output | 5 | Register index being written |
| vr_byte | output | 4 | Register lane being written |
| vr_wdata | output | 8 | Register byte write data |

## Verification
The case hardest to reach is a start that arrives in the middle of a running transfer. The stimulus has to land on a cycle where busy is high and carry a different address and register, so that any leak would show up as stray writes. The bench raises such a start on the first busy cycle of a long quad load and expects only the original transfer's reads and writes. The zero-length rest load (aligned address) and a negative offset that wraps below address zero are also driven on purpose. With these cases, the done timing and address wrap are exercised where they differ most from the plain case.

// File: rtl/qvl_pkg.sv
package qvl_pkg;
  localparam int unsigned VEC_BYTES = 16;
  localparam int unsigned LANE_W    = $clog2(VEC_BYTES);
  localparam int unsigned LEN_W     = LANE_W + 1;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [LEN_W-1:0]  len_t;

  typedef enum logic {
    OP_QUAD = 1'b0,
    OP_REST = 1'b1
  } qvl_op_e;
endpackage

// File: rtl/qvl_rst_sync.sv
module qvl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/qvl_plan.sv
// Combinational range planner: effective address, first read address, length.
module qvl_plan
  import qvl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 7,
  parameter int unsigned MEM_AW = 12
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  input  lane_t             elem,
  input  qvl_op_e           op,
  output logic [MEM_AW-1:0] first_addr,
  output len_t              count
);
  logic [ADDR_W-1:0] ofs_ext;
  logic [MEM_AW-1:0] ea;
  lane_t             lo;
  len_t              room, fwd_avail, back_avail, avail;

  always_comb begin
    ofs_ext    = {{(ADDR_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    ea         = base[MEM_AW-1:0] + (ofs_ext[MEM_AW-1:0] << LANE_W);
    lo         = ea[LANE_W-1:0];
    room       = len_t'(VEC_BYTES) - {1'b0, elem};
    fwd_avail  = len_t'(VEC_BYTES) - {1'b0, lo};
    back_avail = {1'b0, lo};
    avail      = (op == OP_QUAD) ? fwd_avail : back_avail;
    count      = (avail < room) ? avail : room;
    first_addr = (op == OP_QUAD) ? ea : {ea[MEM_AW-1:LANE_W], {LANE_W{1'b0}}};
  end
endmodule

// File: rtl/qvl_seq.sv
// Byte sequencer: one read per cycle, write stage one cycle behind.
module qvl_seq
  import qvl_pkg::*;
#(
  parameter int unsigned MEM_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MEM_AW-1:0] first_addr,
  input  len_t              count,
  input  lane_t             elem,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic              rd_en,
  output logic [MEM_AW-1:0] rd_addr,
  output logic              wr_en,
  output lane_t             wr_lane
);
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  len_t              rem_q, rem_d;
  logic [MEM_AW-1:0] addr_q, addr_d;
  lane_t             lane_q, lane_d;
  logic              wv_q, wv_d;
  lane_t             wlane_q, wlane_d;
  logic              issue, finish;

  always_comb begin
    issue   = busy_q && (rem_q != '0);
    finish  = busy_q && (rem_q == '0);
    accept  = start && !busy_q;
    busy_d  = busy_q;
    rem_d   = rem_q;
    addr_d  = addr_q;
    lane_d  = lane_q;
    wlane_d = wlane_q;
    wv_d    = issue;
    done_d  = finish;
    if (accept) begin
      busy_d = 1'b1;
      rem_d  = count;
      addr_d = first_addr;
      lane_d = elem;
    end else if (issue) begin
      rem_d   = rem_q - len_t'(1);
      addr_d  = addr_q + MEM_AW'(1);
      lane_d  = lane_q + lane_t'(1);
      wlane_d = lane_q;
    end else if (finish) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rem_q   <= '0;
      addr_q  <= '0;
      lane_q  <= '0;
      wv_q    <= 1'b0;
      wlane_q <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      rem_q   <= rem_d;
      addr_q  <= addr_d;
      lane_q  <= lane_d;
      wv_q    <= wv_d;
      wlane_q <= wlane_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_en   = issue;
  assign rd_addr = addr_q;
  assign wr_en   = wv_q;
  assign wr_lane = wlane_q;
endmodule

// File: rtl/quad_vec_load.sv
module quad_vec_load
  import qvl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned OFS_W      = 7,
  parameter int unsigned DMEM_BYTES = 4096,
  parameter int unsigned VREG_N     = 32,
  localparam int unsigned MEM_AW    = $clog2(DMEM_BYTES),
  localparam int unsigned VIDX_W    = $clog2(VREG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [3:0]        elem,
  input  logic [VIDX_W-1:0] vreg,
  output logic              busy,
  output logic              done,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              vr_we,
  output logic [VIDX_W-1:0] vr_idx,
  output logic [3:0]        vr_byte,
  output logic [7:0]        vr_wdata
);
  logic              rst_int_n;
  logic [MEM_AW-1:0] first_addr;
  len_t              count;
  logic              accept;
  logic [VIDX_W-1:0] vidx_q, vidx_d;
  lane_t             wr_lane;

  qvl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  qvl_plan #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .MEM_AW(MEM_AW)) u_plan (
    .base       (base),
    .ofs        (ofs),
    .elem       (lane_t'(elem)),
    .op         (qvl_op_e'(op)),
    .first_addr (first_addr),
    .count      (count)
  );

  qvl_seq #(.MEM_AW(MEM_AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .first_addr (first_addr),
    .count      (count),
    .elem       (lane_t'(elem)),
    .accept     (accept),
    .busy       (busy),
    .done       (done),
    .rd_en      (mem_rd_en),
    .rd_addr    (mem_addr),
    .wr_en      (vr_we),
    .wr_lane    (wr_lane)
  );

  always_comb begin
    vidx_d = vidx_q;
    if (accept) vidx_d = vreg;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) vidx_q <= '0;
    else            vidx_q <= vidx_d;
  end

  assign vr_idx   = vidx_q;
  assign vr_byte  = 4'(wr_lane);
  assign vr_wdata = mem_rdata;
endmodule

// File: rtl/qvl_chk.sv
module qvl_chk #(
  parameter int unsigned MEM_AW = 12,
  parameter int unsigned VIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_rd_en,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              vr_we,
  input logic [VIDX_W-1:0] vr_idx,
  input logic [3:0]        vr_byte
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R7
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |=> vr_we);
  // R7
  wr_has_rd_chk: assert property (@(posedge clk) disable iff (!rst_n) vr_we |-> $past(mem_rd_en));
  // R7
  act_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd_en || vr_we) |-> busy);
  // R3
  lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vr_we && $past(vr_we)) |-> (vr_byte == $past(vr_byte) + 4'd1));
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + MEM_AW'(1)));
  // R10
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vr_we && $past(vr_we)) |-> $stable(vr_idx));
endmodule

bind quad_vec_load qvl_chk #(.MEM_AW(MEM_AW), .VIDX_W(VIDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .mem_rd_en (mem_rd_en),
  .mem_addr  (mem_addr),
  .vr_we     (vr_we),
  .vr_idx    (vr_idx),
  .vr_byte   (vr_byte)
);

// File: tb/quad_vec_load_tb.sv
`timescale 1ns/1ps
module quad_vec_load_tb;
  localparam int MEM_B = 4096;
  localparam int NREG  = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, op;
  logic [31:0] base;
  logic [6:0]  ofs;
  logic [3:0]  elem;
  logic [4:0]  vreg;
  logic        busy, done, mem_rd_en, vr_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_rdata, vr_wdata;
  logic [4:0]  vr_idx;
  logic [3:0]  vr_byte;

  always #2.5 clk = ~clk;

  quad_vec_load u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base(base), .ofs(ofs),
    .elem(elem), .vreg(vreg), .busy(busy), .done(done), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .vr_we(vr_we), .vr_idx(vr_idx),
    .vr_byte(vr_byte), .vr_wdata(vr_wdata)
  );

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  string cur_tag = "R3";

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) ^ (a >> 3) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] vinit(input int r, input int b);
    return 8'(r * 16 + b + 8'h11);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // memory model: synchronous read, one cycle latency
  always @(posedge clk) if (mem_rd_en) mem_rdata <= pat(int'(mem_addr));

  // register file model
  logic [7:0] vrf [NREG*16];
  logic [7:0] exp_vrf [NREG*16];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG*16; i++) vrf[i] <= vinit(i / 16, i % 16);
    end else if (vr_we) begin
      vrf[{vr_idx, vr_byte}] <= vr_wdata;
    end
  end

  typedef struct { logic [4:0] idx; logic [3:0] lane; logic [7:0] data; } wr_t;
  wr_t        wrq[$];
  logic [11:0] rdq[$];

  // monitor: scoreboard side
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (mem_rd_en) begin
        if (rdq.size() == 0) chk(0, "R7", "unexpected read addr", mem_addr, 0);
        else begin
          logic [11:0] a;
          a = rdq.pop_front();
          chk(mem_addr == a, cur_tag, "read address", mem_addr, a);
        end
      end
      if (vr_we) begin
        if (wrq.size() == 0) chk(0, "R6", "unexpected write lane", vr_byte, 0);
        else begin
          wr_t w;
          w = wrq.pop_front();
          chk(vr_idx == w.idx, "R10", "write reg index", vr_idx, w.idx);
          chk(vr_byte == w.lane, cur_tag, "write lane", vr_byte, w.lane);
          chk(vr_wdata == w.data, "R7", "write data", vr_wdata, w.data);
        end
      end
    end
  end

  // driver
  task automatic do_load(input bit o, input logic [31:0] b, input int of, input int el,
                         input int r, input string tag, input bit intrude);
    int ea, lo, st, n, lat, bad;
    ea = int'((b + 32'(of * 16)) & 32'hFFF);
    lo = ea & 15;
    if (!o) begin st = ea;       n = (16 - lo < 16 - el) ? 16 - lo : 16 - el; end
    else    begin st = ea & ~15; n = (lo < 16 - el) ? lo : 16 - el; end
    cur_tag = tag;
    for (int k = 0; k < n; k++) begin
      wr_t w;
      rdq.push_back(12'((st + k) % MEM_B));
      w.idx = 5'(r); w.lane = 4'(el + k); w.data = pat((st + k) % MEM_B);
      wrq.push_back(w);
      exp_vrf[r*16 + el + k] = w.data;
    end
    @(negedge clk);
    op = o; base = b; ofs = 7'(of); elem = 4'(el); vreg = 5'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8", "busy after start", busy, 1);
    if (intrude) begin
      start = 1'b1; op = 1'b0; base = 32'h0; ofs = '0; elem = '0; vreg = 5'(r ^ 1);
    end
    lat = 0;
    while (!done && lat < 64) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    chk(lat == n + 1, "R8", "done latency", lat, n + 1);
    chk(busy == 1'b0, "R8", "busy at done", busy, 0);
    chk(rdq.size() == 0 && wrq.size() == 0, tag, "bytes left unmoved", rdq.size() + wrq.size(), 0);
    bad = 0;
    for (int i = 0; i < NREG*16; i++) if (vrf[i] !== exp_vrf[i]) bad++;
    chk(bad == 0, "R6", "register file mismatches", bad, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done pulse width", done, 0);
    rdq.delete(); wrq.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREG*16; i++) exp_vrf[i] = vinit(i / 16, i % 16);
    rst_n = 1'b0; start = 1'b0; op = 1'b0; base = '0; ofs = '0; elem = '0; vreg = '0;
    repeat (3) @(negedge clk);
    chk({busy, done, mem_rd_en, vr_we} == 4'b0, "R1", "outputs in reset", {busy, done, mem_rd_en, vr_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, mem_rd_en, vr_we} == 4'b0, "R1", "outputs after reset", {busy, done, mem_rd_en, vr_we}, 0);

    do_load(1'b0, 32'h0000_0100,  0,  0,  3, "R4", 1'b0); // full 16 bytes
    do_load(1'b0, 32'h0000_0205,  1,  0,  4, "R3", 1'b1); // ea 0x215, 11 bytes, start ignored
    do_load(1'b0, 32'h0000_07A3,  0, 10,  5, "R4", 1'b0); // lane limit, 6 bytes
    do_load(1'b1, 32'h0000_0309,  0,  0,  6, "R5", 1'b0); // 9 bytes from 0x300
    do_load(1'b1, 32'h0000_0340,  2,  3,  7, "R5", 1'b0); // aligned, zero bytes
    do_load(1'b1, 32'h0000_03AC, -1,  8,  8, "R5", 1'b0); // ea 0x39C, 8 bytes
    do_load(1'b0, 32'h0000_0010, -3,  2,  9, "R9", 1'b0); // wraps to 0xFE0, 14 bytes
    do_load(1'b0, 32'hABCD_E5F0,  0, 15, 31, "R9", 1'b0); // high bits dropped, 1 byte
    do_load(1'b1, 32'hFFFF_FFFF,  0,  0,  0, "R2", 1'b0); // ea 0xFFF, 15 bytes
    do_load(1'b0, 32'h0000_040A,  0,  5,  4, "R6", 1'b0); // overwrite middle of reg 4
    finish_run();
  end
endmodule